// File: doc/BRIEF.md
# Default Memory Region Attribute Decoder

This block keeps one 64-bit configuration word that splits the 32-bit physical address space into three default regions: general system memory at the bottom, device space in the middle, and the boot ROM at the top. Two 4 KB-granular boundaries set the limits. A lookup returns the 8-bit property byte of the region an address falls in, one cycle after the lookup is accepted. A fixed legacy window at 000A0000h–000FFFFFh takes priority over the system memory region. It returns its own programmable property byte and raises a flag.

Software reaches the two registers through a plain write/read port. A write takes an index, data and a write strobe. Reads are combinational from the same index. Lookups flow through a valid/ready stage. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or its result is being consumed in the same cycle. A result stays on the outputs, unchanged, until `res_ready` is seen high while `res_valid` is high.

Property byte encoding: bit 0 cache-disable, bit 1 write-allocate, bit 2 write-protect, bit 3 write-through, bit 4 write-combine, bit 5 write-serialize, bits 7:6 reserved.

Top module: `default_region_decoder`

## Requirements
- R1: After reset, index 00001808h reads 01FFFFF0_10000001h and index 00001809h (legacy window byte) reads 01h. Any other index reads zero.
- R2: A write with `cfg_wr_en` high to index 00001808h or 00001809h replaces that register. A write to any other index changes neither register.
- R3: Bits 7:6 of every property byte read back as zero, and `res_prop[7:6]` is always zero. This covers configuration word bits 63:62, 35:34 and 7:6, and legacy byte bits 7:6.
- R4: An address whose bits 31:12 are at or above the ROM base field (word bits 55:36) returns the ROM byte (bits 63:56) with region code 2.
- R5: An address at or above the system top field (bits 27:8, compared with address bits 31:12) and below the ROM base returns the device byte (bits 35:28) with region code 1.
- R6: An address below the system top and outside the legacy window returns the system byte (bits 7:0) with region code 0 and `res_legacy` low.
- R7: An address in 000A0000h–000FFFFFh that is below the system top and below the ROM base returns the legacy byte with region code 0 and `res_legacy` high.
- R8: When the system top is programmed above the ROM base, the ROM comparison wins. The device region is then empty.
- R9: The result of an accepted lookup is presented with `res_valid` high on the next cycle. It uses the registers as they stood before any write on the same edge. A write affects lookups accepted from the following cycle on.
- R10: While `res_valid` is high and `res_ready` is low, the result outputs hold steady and `in_ready` is low. Otherwise `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 32 | Register index for write and read |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data for `cfg_addr` |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request accepted when high with `in_valid` |
| in_addr | input | 32 | Physical address to classify |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_prop | output | 8 | Property byte of the selected region |
| res_region | output | 2 | 0 system, 1 device, 2 ROM |
| res_legacy | output | 1 | Legacy window override applied |

## Verification
The assertions assume that the consumer only drops `res_ready` as a stall, never as a retraction. They also assume that `in_addr` and `in_valid` are settled before the edge that may accept them. The bench drives every input shortly after the rising edge and checks at the falling edge. It toggles `res_ready` randomly so that stalls start and end in every phase of the pipeline. Its write stimulus also lands on the same edge as accepted lookups, which exercises the old-value rule without ever violating these assumptions.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned PROP_W     = 8;
  localparam int unsigned PAGE_W     = 20;
  localparam int unsigned PAGE_SHIFT = 12;

  // field positions inside the configuration word
  localparam int unsigned SYS_LSB  = 0;
  localparam int unsigned TOP_LSB  = SYS_LSB + PROP_W;
  localparam int unsigned DEV_LSB  = TOP_LSB + PAGE_W;
  localparam int unsigned BASE_LSB = DEV_LSB + PROP_W;
  localparam int unsigned ROM_LSB  = BASE_LSB + PAGE_W;

  // reserved bits 7:6 of each property byte are cleared
  localparam logic [WORD_W-1:0] KEEP_MASK = ~64'hC000000C_000000C0;
  localparam logic [PROP_W-1:0] PROP_KEEP = 8'h3F;

  // fixed legacy window, in 4 KB pages
  localparam logic [PAGE_W-1:0] LEG_LO_PG = 20'h000A0;
  localparam logic [PAGE_W-1:0] LEG_HI_PG = 20'h000FF;

  typedef enum logic [1:0] {
    RGN_SYS = 2'd0,
    RGN_DEV = 2'd1,
    RGN_ROM = 2'd2
  } region_e;

  typedef struct packed {
    logic [PROP_W-1:0] prop;
    region_e           region;
    logic              legacy;
  } result_t;

  function automatic logic [PROP_W-1:0] prop_at(input logic [WORD_W-1:0] w,
                                                input int unsigned lsb);
    return w[lsb +: PROP_W] & PROP_KEEP;
  endfunction

  function automatic logic [PAGE_W-1:0] page_at(input logic [WORD_W-1:0] w,
                                                input int unsigned lsb);
    return w[lsb +: PAGE_W];
  endfunction
endpackage

// File: rtl/drc_cfg_regs.sv
module drc_cfg_regs
  import drc_pkg::*;
#(
  parameter int unsigned        IDX_W   = 32,
  parameter logic [IDX_W-1:0]   CFG_IDX = 32'h0000_1808,
  parameter logic [IDX_W-1:0]   LEG_IDX = 32'h0000_1809,
  parameter logic [WORD_W-1:0]  CFG_RST = 64'h01FF_FFF0_1000_0001,
  parameter logic [PROP_W-1:0]  LEG_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] cfg_q,
  output logic [PROP_W-1:0] leg_q
);
  localparam logic [WORD_W-1:0] CFG_RST_CLEAN = CFG_RST & KEEP_MASK;
  localparam logic [PROP_W-1:0] LEG_RST_CLEAN = LEG_RST & PROP_KEEP;

  logic hit_cfg;
  logic hit_leg;

  assign hit_cfg = (idx == CFG_IDX);
  assign hit_leg = (idx == LEG_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RST_CLEAN;
    end else if (wr_en && hit_cfg) begin
      cfg_q <= wdata & KEEP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leg_q <= LEG_RST_CLEAN;
    end else if (wr_en && hit_leg) begin
      leg_q <= wdata[PROP_W-1:0] & PROP_KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_cfg) begin
      rdata = cfg_q;
    end else if (hit_leg) begin
      rdata = {{(WORD_W-PROP_W){1'b0}}, leg_q};
    end
  end
endmodule

// File: rtl/drc_region_match.sv
module drc_region_match
  import drc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] cfg,
  input  logic [PROP_W-1:0] leg_prop,
  output result_t           res
);
  localparam int unsigned NUM_BND = 2;  // 0: ROM base, 1: system top

  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] bnd [NUM_BND];
  logic [NUM_BND-1:0] at_or_above;
  logic in_window;

  assign page   = addr[ADDR_W-1 -: PAGE_W];
  assign bnd[0] = page_at(cfg, BASE_LSB);
  assign bnd[1] = page_at(cfg, TOP_LSB);

  for (genvar g = 0; g < NUM_BND; g++) begin : g_cmp
    assign at_or_above[g] = (page >= bnd[g]);
  end

  assign in_window = (page >= LEG_LO_PG) && (page <= LEG_HI_PG);

  always_comb begin
    res.legacy = 1'b0;
    if (at_or_above[0]) begin
      res.region = RGN_ROM;
      res.prop   = prop_at(cfg, ROM_LSB);
    end else if (at_or_above[1]) begin
      res.region = RGN_DEV;
      res.prop   = prop_at(cfg, DEV_LSB);
    end else if (in_window) begin
      res.region = RGN_SYS;
      res.prop   = leg_prop & PROP_KEEP;
      res.legacy = 1'b1;
    end else begin
      res.region = RGN_SYS;
      res.prop   = prop_at(cfg, SYS_LSB);
    end
  end
endmodule

// File: rtl/drc_out_stage.sv
module drc_out_stage #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign up_ready = !v_q || dn_ready;
  assign dn_valid = v_q;
  assign dn_data  = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (up_ready) begin
      v_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= '0;
    end else if (up_valid && up_ready) begin
      d_q <= up_data;
    end
  end
endmodule

// File: rtl/default_region_decoder.sv
module default_region_decoder
  import drc_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [31:0]       CFG_IDX = 32'h0000_1808,
  parameter logic [31:0]       LEG_IDX = 32'h0000_1809
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] cfg_addr,
  input  logic        cfg_wr_en,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_addr,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [7:0]  res_prop,
  output logic [1:0]  res_region,
  output logic        res_legacy
);
  localparam int unsigned RES_W = $bits(result_t);

  logic [WORD_W-1:0] cfg_q;
  logic [PROP_W-1:0] leg_q;
  result_t           lookup;
  result_t           held;
  logic [RES_W-1:0]  held_bits;

  drc_cfg_regs #(
    .IDX_W  (32),
    .CFG_IDX(CFG_IDX),
    .LEG_IDX(LEG_IDX)
  ) u_regs (
    .clk  (clk),
    .rst  (rst),
    .idx  (cfg_addr),
    .wr_en(cfg_wr_en),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .cfg_q(cfg_q),
    .leg_q(leg_q)
  );

  drc_region_match #(.ADDR_W(ADDR_W)) u_match (
    .addr    (in_addr),
    .cfg     (cfg_q),
    .leg_prop(leg_q),
    .res     (lookup)
  );

  drc_out_stage #(.W(RES_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (lookup),
    .dn_valid(res_valid),
    .dn_ready(res_ready),
    .dn_data (held_bits)
  );

  assign held       = result_t'(held_bits);
  assign res_prop   = held.prop;
  assign res_region = held.region;
  assign res_legacy = held.legacy;
endmodule

// File: rtl/drc_checker.sv
module drc_checker
  import drc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [7:0]  res_prop,
  input logic [1:0]  res_region,
  input logic        res_legacy,
  input logic [63:0] cfg_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_prop) && $stable(res_region) && $stable(res_legacy)); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_prop[7:6] == 2'b00); // R3

  AST_ROM_WINS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_addr[31:12] >= cfg_q[55:36]) |=> res_region == 2'd2); // R4

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> res_valid); // R9

  AST_LEGACY_SYS: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_legacy |-> res_region == 2'd0); // R7
endmodule

bind default_region_decoder drc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_prop  (res_prop),
  .res_region(res_region),
  .res_legacy(res_legacy),
  .cfg_q     (cfg_q)
);

// File: tb/default_region_decoder_tb.sv
module default_region_decoder_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] IDX_CFG = 32'h0000_1808;
  localparam logic [31:0] IDX_LEG = 32'h0000_1809;
  localparam logic [63:0] RSV_CLR = 64'h3FFF_FFF3_FFFF_FF3F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [7:0]  res_prop;
  logic [1:0]  res_region;
  logic        res_legacy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  default_region_decoder u_dut (
    .clk(clk), .rst(rst),
    .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_prop(res_prop), .res_region(res_region), .res_legacy(res_legacy)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0] m_cfg;
  logic [7:0]  m_leg;
  bit          m_valid;
  logic [7:0]  m_prop;
  int          m_region;
  bit          m_legacy;

  function automatic void classify(input logic [31:0] a, input logic [63:0] w, input logic [7:0] lg,
                                   output logic [7:0] p, output int r, output bit l);
    longint unsigned pg, base, top;
    pg = a >> 12;
    base = (w >> 36) & 64'hFFFFF;
    top = (w >> 8) & 64'hFFFFF;
    l = 0;
    if (pg >= base) begin r = 2; p = w[63:56]; end
    else if (pg >= top) begin r = 1; p = w[35:28]; end
    else if (a >= 32'h000A_0000 && a <= 32'h000F_FFFF) begin r = 0; p = lg; l = 1; end
    else begin r = 0; p = w[7:0]; end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 64'h01FF_FFF0_1000_0001;
      m_leg = 8'h01;
      m_valid = 0;
    end else begin
      if (in_valid && (!m_valid || res_ready)) begin
        m_valid = 1;
        classify(in_addr, m_cfg, m_leg, m_prop, m_region, m_legacy);
      end else if (res_ready) begin
        m_valid = 0;
      end
      if (cfg_wr_en && cfg_addr == IDX_CFG) m_cfg = cfg_wdata & RSV_CLR;
      if (cfg_wr_en && cfg_addr == IDX_LEG) m_leg = cfg_wdata[7:0] & 8'h3F;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      logic [63:0] exp_rd;
      exp_rd = (cfg_addr == IDX_CFG) ? m_cfg : (cfg_addr == IDX_LEG) ? {56'd0, m_leg} : 64'd0;
      check(cfg_rdata == exp_rd, "R2 readback", cfg_rdata, exp_rd);
      check(res_valid == m_valid, "R9 res_valid", res_valid, m_valid);
      check(in_ready == (!m_valid || res_ready), "R10 in_ready", in_ready, (!m_valid || res_ready));
      if (m_valid && res_valid)
        check({res_prop, res_region, res_legacy} == {m_prop, m_region[1:0], m_legacy},
              "R4/R5/R6/R7 lookup", {res_prop, res_region, res_legacy},
              {m_prop, m_region[1:0], m_legacy});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] idx, input logic [63:0] d);
    cfg_addr = idx; cfg_wdata = d; cfg_wr_en = 1'b1;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [31:0] idx, input logic [63:0] exp, input string req);
    cfg_addr = idx;
    @(negedge clk);
    check(cfg_rdata == exp, req, cfg_rdata, exp);
    step();
  endtask

  task automatic look(input logic [31:0] a, input logic [7:0] p, input logic [1:0] r, input bit l,
                      input string req);
    in_addr = a; in_valid = 1'b1; res_ready = 1'b1;
    step();
    in_valid = 1'b0;
    @(negedge clk);
    check(res_valid && {res_prop, res_region, res_legacy} == {p, r, l}, req,
          {res_valid, res_prop, res_region, res_legacy}, {1'b1, p, r, l});
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && in_ready == 1'b1, "R1 reset outputs", {res_valid, in_ready}, 2'b01);
    step();
    rd_check(IDX_CFG, 64'h01FF_FFF0_1000_0001, "R1 reset word");
    rd_check(IDX_LEG, 64'h01, "R1 reset legacy byte");
    rd_check(32'h0000_1800, 64'h0, "R1 unmapped index");
    // reset map: top page 0, base FFFFF -> device below the top page
    look(32'h1234_5678, 8'h01, 2'd1, 1'b0, "R5 reset device");
    look(32'hFFFF_F000, 8'h01, 2'd2, 1'b0, "R4 reset rom");
    // R2: write to other index ignored
    wr(32'h0000_1807, 64'hDEAD_BEEF_DEAD_BEEF);
    rd_check(IDX_CFG, 64'h01FF_FFF0_1000_0001, "R2 ignored write");
    rd_check(IDX_LEG, 64'h01, "R2 ignored write legacy");
    // R3: reserved bits clear
    wr(IDX_CFG, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(IDX_LEG, 64'hFF);
    rd_check(IDX_CFG, 64'h3FFF_FFF3_FFFF_FF3F, "R3 reserved word");
    rd_check(IDX_LEG, 64'h3F, "R3 reserved legacy");
    look(32'hFFFF_F000, 8'h3F, 2'd2, 1'b0, "R3 rom byte masked");
    // program map
    wr(IDX_CFG, {8'h05, 20'hFFF00, 8'h11, 20'h08000, 8'h0A});
    wr(IDX_LEG, 64'h21);
    look(32'hFFF0_0000, 8'h05, 2'd2, 1'b0, "R4 rom at base");
    look(32'hFFEF_FFFF, 8'h11, 2'd1, 1'b0, "R5 below base");
    look(32'h0800_0000, 8'h11, 2'd1, 1'b0, "R5 at top");
    look(32'h07FF_FFFF, 8'h0A, 2'd0, 1'b0, "R6 below top");
    look(32'h0009_FFFF, 8'h0A, 2'd0, 1'b0, "R6 under window");
    look(32'h0010_0000, 8'h0A, 2'd0, 1'b0, "R6 over window");
    look(32'h000A_0000, 8'h21, 2'd0, 1'b1, "R7 window low");
    look(32'h000F_FFFF, 8'h21, 2'd0, 1'b1, "R7 window high");
    // R8: top above base
    wr(IDX_CFG, {8'h09, 20'h80000, 8'h12, 20'hFFFFF, 8'h04});
    look(32'h8000_0000, 8'h09, 2'd2, 1'b0, "R8 rom wins");
    look(32'hFFFF_FFFF, 8'h09, 2'd2, 1'b0, "R8 top of space");
    look(32'h7FFF_FFFF, 8'h04, 2'd0, 1'b0, "R8 no device");
    // R9: write on the same edge as an accept
    cfg_addr = IDX_CFG; cfg_wdata = {8'h07, 20'h00000, 8'h00, 20'h00000, 8'h00}; cfg_wr_en = 1'b1;
    in_addr = 32'h0000_0000; in_valid = 1'b1;
    step();
    cfg_wr_en = 1'b0;
    @(negedge clk);
    check(res_prop == 8'h04 && res_region == 2'd0, "R9 old value same edge", {res_prop, res_region}, {8'h04, 2'd0});
    step();
    in_valid = 1'b0;
    @(negedge clk);
    check(res_prop == 8'h07 && res_region == 2'd2, "R9 new value next cycle", {res_prop, res_region}, {8'h07, 2'd2});
    step();
    // R10: stall holds
    in_addr = 32'h1000_0000; in_valid = 1'b1; res_ready = 1'b0;
    step();
    in_addr = 32'h2000_0000;
    repeat (3) begin
      @(negedge clk);
      check(res_valid && !in_ready && res_prop == 8'h07, "R10 stall hold", {res_valid, in_ready, res_prop}, {2'b10, 8'h07});
      step();
    end
    res_ready = 1'b1; in_valid = 1'b0;
    step();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 7);
      in_valid = $urandom_range(0, 3) != 0;
      res_ready = $urandom_range(0, 3) != 0;
      case (sel)
        0: in_addr = 32'h000A_0000 + $urandom_range(0, 32'h5FFFF);
        1: in_addr = {u_rand20(), 12'h000};
        2: in_addr = {u_rand20(), 12'hFFF};
        default: in_addr = $urandom;
      endcase
      cfg_wr_en = ($urandom_range(0, 15) == 0);
      cfg_addr = ($urandom_range(0, 2) == 0) ? IDX_LEG : ($urandom_range(0, 5) == 0 ? 32'h0000_1810 : IDX_CFG);
      cfg_wdata = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) cfg_wdata[55:36] = 20'hFFF00 + 20'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) cfg_wdata[27:8] = 20'($urandom_range(0, 20'h400));
      step();
    end
    cfg_wr_en = 1'b0; in_valid = 1'b0; res_ready = 1'b1;
    repeat (2) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [19:0] u_rand20();
    return ($urandom_range(0, 1) == 1) ? 20'(32'h000A0 + $urandom_range(0, 95))
                                       : 20'(32'hFFF00 + $urandom_range(0, 255));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule